// File: doc/BRIEF.md
# Triggered Delay Counter with Buffered Reload

This block runs a counter that starts from zero on a trigger event and emits one-clock pulses on each channel output when the count reaches that channel's delay value. The trigger comes either from a rising edge on an external input or from a software write, depending on a source-select bit. The count advances once per divided tick. The tick period is a power of two, chosen as the sum of a prescale code and a multiplier code. At the period value the counter either stops or wraps to zero.

The period and channel delays are double-buffered. Software writes the buffers and then arms a load request. A two-bit load mode then picks the moment the buffers reach the working registers: on the next clock, at counter wrap, at a trigger event, or at whichever of wrap and trigger comes first. Every channel keeps a hit flag. It also raises an error flag if it fires again before software has acknowledged the previous hit. A maskable interrupt reports any error flag.

Register map (word addresses): 0 control, 1 period buffer, 2 status, 4+i delay buffer of channel i. Control bits: 0 enable, 1 continuous, 3:2 load mode, 4 load request, 5 software trigger, 6 trigger source (1 = software), 7 error interrupt enable, 10:8 prescale code, 12:11 multiplier code.

Top module: `dly_trig_ctr`

## Requirements
- R1: After reset, the control and status registers read 0, and all pulse outputs and the interrupt output are low.
- R2: Control bits 31:13 and the software trigger bit 5 always read as 0, whatever was written to them.
- R3: Writing 1 to control bit 4 arms a pending load, and bit 4 reads 1 until the transfer. Writes to the period and delay buffers have no effect on pulse timing until a transfer happens.
- R4: With load mode 00, the transfer happens on the clock edge after the edge that armed it.
- R5: With load mode 01, the transfer happens on the edge where the counter wraps from the period value.
- R6: With load mode 10, the transfer happens on the edge of a trigger event, and the run restarted by that trigger already uses the new values.
- R7: With load mode 11, the transfer happens at the first wrap or trigger event.
- R8: When enabled, a trigger event resets the counter to 0 and starts it. With bit 6 = 1 the event is a write of 1 to bit 5. With bit 6 = 0 the event is a rising edge of trig_in, and a write to bit 5 is ignored.
- R9: The counter steps once every 2^(prescale+multiplier) clocks. Channel i pulses for one clock at edge t0 + d*div + 1, where t0 is the trigger edge and d is its delay. At the period value the counter stops, or, when continuous, it wraps to 0 one step later.
- R10: Status bit i is the hit flag of channel i, and bit NCH+i is its error flag. A pulse sets the hit flag. A pulse while the hit flag is set also sets the error flag. Writing 1 clears either flag. A pulse on the same edge as a hit acknowledge leaves the hit flag set and the error flag clear.
- R11: irq is high one clock after any error flag is set while bit 7 is 1, and low otherwise.
- R12: While enable is 0, the counter is held at 0, stopped, and no pulses occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | AW | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the address of the previous clock |
| trig_in | input | 1 | External trigger, rising edge counts |
| ch_pulse | output | NCH | One-clock delay-match pulses |
| irq | output | 1 | Masked error interrupt |

## Verification
Two events can land on one clock edge: a channel's new match and a software acknowledge of that channel's hit flag. The bench times a status write so that its edge coincides with a restarted run's delay-0 pulse, then reads status. The expected result is the hit still set and no error flag. The bench also makes a trigger coincide with a pending load in trigger mode. It judges the transfer by pulse timing: the restarted run must already follow the new delays.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
  localparam int PRE_BITS = 3;
  localparam int MUL_BITS = 2;

  localparam int A_CTRL   = 0;
  localparam int A_PERIOD = 1;
  localparam int A_STATUS = 2;
  localparam int A_DLY0   = 4;

  localparam int B_EN   = 0;
  localparam int B_CONT = 1;
  localparam int B_MODE = 2;
  localparam int B_LDOK = 4;
  localparam int B_SWT  = 5;
  localparam int B_SRC  = 6;
  localparam int B_IE   = 7;
  localparam int B_PRE  = 8;
  localparam int B_MUL  = 11;

  typedef enum logic [1:0] {
    LD_NOW    = 2'b00,
    LD_WRAP   = 2'b01,
    LD_TRIG   = 2'b10,
    LD_EITHER = 2'b11
  } ld_mode_e;

  typedef struct packed {
    logic [MUL_BITS-1:0] mul_sel;
    logic [PRE_BITS-1:0] pre_sel;
    logic                ie;
    logic                sw_src;
    logic [1:0]          mode;
    logic                cont;
    logic                en;
  } ctrl_t;
endpackage

// File: rtl/dtc_timebase.sv
module dtc_timebase
  import dtc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic                cont,
  input  logic [PRE_BITS-1:0] pre_sel,
  input  logic [MUL_BITS-1:0] mul_sel,
  input  logic                trig_evt,
  input  logic [CNT_W-1:0]    period_w,
  output logic [CNT_W-1:0]    cnt,
  output logic                cnt_upd,
  output logic                running,
  output logic                wrap_evt
);
  localparam int DIV_W = (2**PRE_BITS) + (2**MUL_BITS) - 1;
  localparam int SH_W  = $clog2(DIV_W);

  logic [DIV_W-1:0] pre_cnt;
  logic [DIV_W-1:0] div_m1;
  logic [SH_W-1:0]  shift;
  logic             tick;

  assign shift    = SH_W'(pre_sel) + SH_W'(mul_sel);
  assign div_m1   = (DIV_W'(1) << shift) - DIV_W'(1);
  assign tick     = running && (pre_cnt == div_m1);
  assign wrap_evt = tick && (cnt == period_w);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt     <= '0;
      running <= 1'b0;
      pre_cnt <= '0;
      cnt_upd <= 1'b0;
    end else begin
      cnt_upd <= 1'b0;
      if (trig_evt) begin
        cnt     <= '0;
        running <= 1'b1;
        pre_cnt <= '0;
        cnt_upd <= 1'b1;
      end else if (running) begin
        if (tick) begin
          pre_cnt <= '0;
          if (cnt == period_w) begin
            if (cont) begin
              cnt     <= '0;
              cnt_upd <= 1'b1;
            end else begin
              running <= 1'b0;
            end
          end else begin
            cnt     <= cnt + CNT_W'(1);
            cnt_upd <= 1'b1;
          end
        end else begin
          pre_cnt <= pre_cnt + DIV_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/dtc_chan.sv
module dtc_chan #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt,
  input  logic             cnt_upd,
  input  logic [CNT_W-1:0] dly,
  input  logic             ack_hit,
  input  logic             ack_err,
  output logic             pulse,
  output logic             hit,
  output logic             err
);
  logic match;

  assign match = cnt_upd && (cnt == dly);

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse <= 1'b0;
      hit   <= 1'b0;
      err   <= 1'b0;
    end else begin
      pulse <= match;
      // a new match wins over an acknowledge on the same edge
      if (match)        hit <= 1'b1;
      else if (ack_hit) hit <= 1'b0;
      if (match && hit && !ack_hit) err <= 1'b1;
      else if (ack_err)             err <= 1'b0;
    end
  end
endmodule

// File: rtl/dtc_regs.sv
module dtc_regs
  import dtc_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int NCH   = 2,
  parameter int AW    = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      bus_we,
  input  logic [AW-1:0]             bus_addr,
  input  logic [31:0]               bus_wdata,
  output logic [31:0]               bus_rdata,
  input  logic                      trig_in,
  input  logic                      wrap_evt,
  input  logic [NCH-1:0]            hit,
  input  logic [NCH-1:0]            err,
  output ctrl_t                     ctrl,
  output logic                      trig_evt,
  output logic                      ldok_pend,
  output logic                      ldok_wr,
  output logic [CNT_W-1:0]          period_w,
  output logic [NCH-1:0][CNT_W-1:0] dly_w,
  output logic [NCH-1:0]            ack_hit,
  output logic [NCH-1:0]            ack_err
);
  logic [CNT_W-1:0]          period_b;
  logic [NCH-1:0][CNT_W-1:0] dly_b;
  logic                      wr_ctrl, wr_stat, sw_wr, trig_q, load;
  logic [31:0]               rd_nxt;
  logic                      unused_wbits;

  assign unused_wbits = ^bus_wdata;
  assign wr_ctrl  = bus_we && (bus_addr == AW'(A_CTRL));
  assign wr_stat  = bus_we && (bus_addr == AW'(A_STATUS));
  assign ldok_wr  = wr_ctrl && bus_wdata[B_LDOK];
  assign sw_wr    = wr_ctrl && bus_wdata[B_SWT];
  assign trig_evt = ctrl.en && (ctrl.sw_src ? sw_wr : (trig_in && !trig_q));
  assign load     = ldok_pend && ((ctrl.mode == LD_NOW)
                                  || (ctrl.mode[0] && wrap_evt)
                                  || (ctrl.mode[1] && trig_evt));
  assign ack_hit  = wr_stat ? bus_wdata[NCH-1:0]     : '0;
  assign ack_err  = wr_stat ? bus_wdata[2*NCH-1:NCH] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl      <= '0;
      ldok_pend <= 1'b0;
      trig_q    <= 1'b0;
      period_b  <= '0;
      period_w  <= '0;
      dly_b     <= '0;
      dly_w     <= '0;
    end else begin
      trig_q <= trig_in;
      if (wr_ctrl) begin
        ctrl.en      <= bus_wdata[B_EN];
        ctrl.cont    <= bus_wdata[B_CONT];
        ctrl.mode    <= bus_wdata[B_MODE +: 2];
        ctrl.sw_src  <= bus_wdata[B_SRC];
        ctrl.ie      <= bus_wdata[B_IE];
        ctrl.pre_sel <= bus_wdata[B_PRE +: PRE_BITS];
        ctrl.mul_sel <= bus_wdata[B_MUL +: MUL_BITS];
      end
      if (ldok_wr)   ldok_pend <= 1'b1;
      else if (load) ldok_pend <= 1'b0;
      if (bus_we && (bus_addr == AW'(A_PERIOD))) period_b <= bus_wdata[CNT_W-1:0];
      for (int i = 0; i < NCH; i++) begin
        if (bus_we && (bus_addr == AW'(A_DLY0 + i))) dly_b[i] <= bus_wdata[CNT_W-1:0];
      end
      if (load) begin
        period_w <= period_b;
        dly_w    <= dly_b;
      end
    end
  end

  always_comb begin
    rd_nxt = '0;
    if (bus_addr == AW'(A_CTRL))
      rd_nxt = {19'd0, ctrl.mul_sel, ctrl.pre_sel, ctrl.ie, ctrl.sw_src,
                1'b0, ldok_pend, ctrl.mode, ctrl.cont, ctrl.en};
    else if (bus_addr == AW'(A_PERIOD))
      rd_nxt = 32'(period_b);
    else if (bus_addr == AW'(A_STATUS))
      rd_nxt = 32'({err, hit});
    for (int i = 0; i < NCH; i++) begin
      if (bus_addr == AW'(A_DLY0 + i)) rd_nxt = 32'(dly_b[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_nxt;
  end
endmodule

// File: rtl/dly_trig_ctr.sv
module dly_trig_ctr
  import dtc_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int NCH   = 2,
  parameter int AW    = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           bus_we,
  input  logic [AW-1:0]  bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  input  logic           trig_in,
  output logic [NCH-1:0] ch_pulse,
  output logic           irq
);
  ctrl_t                     ctrl;
  logic                      trig_evt, ldok_pend, ldok_wr, wrap_evt, running, cnt_upd;
  logic [CNT_W-1:0]          cnt, period_w;
  logic [NCH-1:0][CNT_W-1:0] dly_w;
  logic [NCH-1:0]            hit, err, ack_hit, ack_err;
  logic                      en, ie;
  logic [1:0]                ldmode;

  assign en     = ctrl.en;
  assign ie     = ctrl.ie;
  assign ldmode = ctrl.mode;

  dtc_regs #(.CNT_W(CNT_W), .NCH(NCH), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .trig_in(trig_in),
    .wrap_evt(wrap_evt), .hit(hit), .err(err), .ctrl(ctrl),
    .trig_evt(trig_evt), .ldok_pend(ldok_pend), .ldok_wr(ldok_wr),
    .period_w(period_w), .dly_w(dly_w), .ack_hit(ack_hit), .ack_err(ack_err)
  );

  dtc_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst(rst), .en(en), .cont(ctrl.cont),
    .pre_sel(ctrl.pre_sel), .mul_sel(ctrl.mul_sel), .trig_evt(trig_evt),
    .period_w(period_w), .cnt(cnt), .cnt_upd(cnt_upd),
    .running(running), .wrap_evt(wrap_evt)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dtc_chan #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst(rst), .cnt(cnt), .cnt_upd(cnt_upd), .dly(dly_w[g]),
      .ack_hit(ack_hit[g]), .ack_err(ack_err[g]),
      .pulse(ch_pulse[g]), .hit(hit[g]), .err(err[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= ie && (|err);
  end
endmodule

// File: rtl/dtc_chk.sv
module dtc_chk #(
  parameter int CNT_W = 16,
  parameter int NCH   = 2,
  parameter int AW    = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [AW-1:0]    bus_addr,
  input logic [31:0]      bus_rdata,
  input logic             irq,
  input logic             en,
  input logic             ie,
  input logic             ldok_pend,
  input logic             ldok_wr,
  input logic             running,
  input logic [1:0]       ldmode,
  input logic [CNT_W-1:0] cnt,
  input logic [NCH-1:0]   hit,
  input logic [NCH-1:0]   err
);
  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == '0) |=> (bus_rdata[31:13] == '0 && !bus_rdata[5]));

  assert_now_load_R4: assert property (@(posedge clk) disable iff (rst)
    (ldok_pend && ldmode == 2'b00 && !ldok_wr) |=> !ldok_pend);

  assert_irq_masked_R11: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(ie));

  assert_idle_off_R12: assert property (@(posedge clk) disable iff (rst)
    !en |=> (cnt == '0 && !running));

  for (genvar g = 0; g < NCH; g++) begin : g_err
    assert_err_after_hit_R10: assert property (@(posedge clk) disable iff (rst)
      $rose(err[g]) |-> $past(hit[g]));
  end
endmodule

bind dly_trig_ctr dtc_chk #(.CNT_W(CNT_W), .NCH(NCH), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .irq(irq), .en(en), .ie(ie), .ldok_pend(ldok_pend), .ldok_wr(ldok_wr),
  .running(running), .ldmode(ldmode), .cnt(cnt), .hit(hit), .err(err)
);

// File: tb/tb_dly_trig_ctr.sv
module tb_dly_trig_ctr;
  localparam int NCH = 2;
  localparam int AW  = 4;
  localparam int A_CTRL = 0, A_PERIOD = 1, A_STATUS = 2, A_DLY0 = 4, A_DLY1 = 5;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           bus_we = 1'b0;
  logic [AW-1:0]  bus_addr = '0;
  logic [31:0]    bus_wdata = '0;
  logic [31:0]    bus_rdata;
  logic           trig_in = 1'b0;
  logic [NCH-1:0] ch_pulse;
  logic           irq;

  dly_trig_ctr #(.CNT_W(16), .NCH(NCH), .AW(AW)) dut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .trig_in(trig_in),
    .ch_pulse(ch_pulse), .irq(irq)
  );

  always #5 clk = ~clk;

  typedef struct {
    int    ch;
    int    cyc;
    string tag;
  } exp_t;

  exp_t q[$];
  exp_t mon_e;
  int   cyc = 0;
  int   vectors = 0;
  int   miscompares = 0;
  int   pulses_seen = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic push(input int ch, input int c, input string tag);
    exp_t e;
    e.ch = ch; e.cyc = c; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic wr(input int a, input logic [31:0] d, output int edge_t);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    edge_t = cyc + 1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = AW'(a);
    @(negedge clk);
    v = bus_rdata;
  endtask

  // scoreboard monitor: pulses must match queued channel and cycle
  always @(negedge clk) begin
    if (!rst) begin
      for (int i = 0; i < NCH; i++) begin
        if (ch_pulse[i]) begin
          pulses_seen++;
          vectors++;
          if (q.size() == 0) begin
            miscompares++;
            $display("FAIL R9: pulse ch %0d at cycle %0d, expected no pulse", i, cyc);
          end else begin
            mon_e = q.pop_front();
            if (mon_e.ch != i || mon_e.cyc != cyc) begin
              miscompares++;
              $display("FAIL %s: pulse ch %0d at cycle %0d, expected ch %0d at cycle %0d",
                       mon_e.tag, i, cyc, mon_e.ch, mon_e.cyc);
            end
          end
        end
      end
      if (q.size() > 0 && q[0].cyc < cyc) begin
        mon_e = q.pop_front();
        vectors++;
        miscompares++;
        $display("FAIL %s: no pulse by cycle %0d, expected ch %0d at cycle %0d",
                 mon_e.tag, cyc, mon_e.ch, mon_e.cyc);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run still busy at cycle %0d, expected completion", cyc);
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int t0, t1, w, d, p0;

    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(A_CTRL, v);   chk("R1 ctrl", v, 32'h0);
    rd(A_STATUS, v); chk("R1 status", v, 32'h0);
    chk("R1 outputs", {29'd0, irq, ch_pulse}, 32'h0);

    // R2 reserved bits and trigger bit read zero
    wr(A_CTRL, 32'hFFFF_E020, d);
    rd(A_CTRL, v); chk("R2 reserved", v, 32'h0);

    // R4 immediate load, then software trigger (R8, R9)
    wr(A_PERIOD, 10, d);
    wr(A_DLY0, 3, d);
    wr(A_DLY1, 7, d);
    wr(A_CTRL, 32'h51, d);
    rd(A_CTRL, v); chk("R4 load done", v, 32'h41);
    wr(A_CTRL, 32'h61, t0);
    push(0, t0 + 4, "R9");
    push(1, t0 + 8, "R9");
    repeat (20) @(negedge clk);
    rd(A_STATUS, v); chk("R10 hits", v, 32'h3);

    // R3 buffer write without load request changes nothing
    wr(A_DLY0, 5, d);
    wr(A_CTRL, 32'h61, t0);
    push(0, t0 + 4, "R3");
    push(1, t0 + 8, "R3");
    repeat (20) @(negedge clk);
    rd(A_STATUS, v); chk("R10 errors", v, 32'hF);
    chk("R11 masked", {31'd0, irq}, 32'h0);
    wr(A_CTRL, 32'hC1, d);
    @(negedge clk);
    chk("R11 raised", {31'd0, irq}, 32'h1);
    wr(A_STATUS, 32'hF, d);
    @(negedge clk);
    chk("R11 cleared", {31'd0, irq}, 32'h0);

    // R5 load at wrap, continuous
    wr(A_PERIOD, 4, d);
    wr(A_DLY1, 2, d);
    wr(A_CTRL, 32'h47, d);
    wr(A_CTRL, 32'h67, t0);
    push(0, t0 + 4, "R5");
    push(1, t0 + 8, "R5");
    wr(A_CTRL, 32'h57, d);
    rd(A_CTRL, v); chk("R3 pending", v, 32'h57);
    w = t0 + 11;
    push(1, w + 3, "R5");
    push(1, w + 8, "R5");
    push(1, w + 13, "R5");
    while (cyc < w + 13) @(negedge clk);
    wr(A_CTRL, 32'h0, d);
    p0 = pulses_seen;
    repeat (10) @(negedge clk);
    chk("R12 no pulses", pulses_seen - p0, 0);
    wr(A_STATUS, 32'hF, d);

    // R6 load on external trigger; R8 software trigger ignored
    wr(A_PERIOD, 6, d);
    wr(A_DLY0, 1, d);
    wr(A_DLY1, 4, d);
    wr(A_CTRL, 32'h19, d);
    p0 = pulses_seen;
    wr(A_CTRL, 32'h29, d);
    repeat (5) @(negedge clk);
    chk("R8 ignored pulses", pulses_seen - p0, 0);
    rd(A_CTRL, v); chk("R8 still pending", v, 32'h19);
    @(negedge clk);
    trig_in = 1'b1; t1 = cyc + 1;
    push(0, t1 + 2, "R6");
    push(1, t1 + 5, "R6");
    @(negedge clk);
    trig_in = 1'b0;
    repeat (15) @(negedge clk);
    rd(A_CTRL, v); chk("R6 load done", v, 32'h09);
    wr(A_STATUS, 32'hF, d);

    // R7 first of wrap/trigger, divide by 4; R10 acknowledge coincides with match
    wr(A_CTRL, 32'h90F, d);
    @(negedge clk);
    trig_in = 1'b1; t0 = cyc + 1;
    push(0, t0 + 5, "R7");
    push(1, t0 + 17, "R7");
    @(negedge clk);
    trig_in = 1'b0;
    wr(A_PERIOD, 3, d);
    wr(A_DLY0, 2, d);
    wr(A_DLY1, 0, d);
    wr(A_CTRL, 32'h91F, d);
    wr(A_STATUS, 32'h1, d);
    while (cyc < t0 + 20) @(negedge clk);
    trig_in = 1'b1; t1 = cyc + 1;
    push(1, t1 + 1, "R7");
    push(0, t1 + 9, "R7");
    @(negedge clk);
    trig_in = 1'b0;
    bus_we = 1'b1; bus_addr = AW'(A_STATUS); bus_wdata = 32'h2;
    @(negedge clk);
    bus_we = 1'b0;
    while (cyc < t1 + 11) @(negedge clk);
    wr(A_CTRL, 32'h0, d);
    repeat (10) @(negedge clk);
    rd(A_STATUS, v); chk("R10 ack with match", v, 32'h3);
    chk("R11 idle", {31'd0, irq}, 32'h0);

    repeat (5) @(negedge clk);
    chk("R9 queue drained", q.size(), 0);
    finish_run();
  end
endmodule